// File: doc/BRIEF.md
# Two-Stage Watchdog With Write Unlock

This block is a watchdog timer with a small bank of registers. Once software enables it, a prescaler divides the system clock into ticks. A first-stage counter counts down from its preload. When it expires, the block can raise a one-cycle interrupt pulse. It then counts down a second-stage preload. When that stage also expires, the block asserts a one-cycle system reset request and restarts from stage one.

Software keeps the system alive by restarting the countdown before it expires. A sticky timeout flag records that a watchdog reset request happened, and only power-on reset or a deliberate clear removes it.

The two preload registers and the reload register are protected. A write to any of them takes effect only directly after the two key words 0x80 and 0x86 have been written, in that order, to the reload register. A configuration register and an enable register are never protected. Register access is a plain synchronous port: a write strobe with address and data, and read data that follows the address combinationally. No data stream passes through the block, so it has no valid/ready handshake and every pin is plain control or status.

Top module: `wdog_top`

## Requirements
- R1: Writing 0x80 and then 0x86 to the reload register (address 4) arms exactly one following write to a protected register. The protected registers are stage-one preload (address 2), stage-two preload (address 3) and reload (address 4). A second protected write afterwards is ignored.
- R2: A protected-register write is ignored unless the full key sequence came directly before it. A write to a protected register that is not the expected next key returns the sequence to its start. Writes to the configuration register (address 0) and the enable register (address 1) leave the sequence alone.
- R3: Configuration bit 0 selects the tick period. When it is 1, one tick occurs every DIV_FAST clock cycles (default 32). When it is 0, one tick occurs every DIV_SLOW cycles (default 32768).
- R4: Writing 1 to enable bit 0 (address 1) while the block is disabled loads the stage-one preload and restarts the prescaler. Writing 0 disables the block.
- R5: With stage-one preload P (a value of 0 counts as 1) and tick period D, irq_o is high for exactly one cycle, P*D clock edges after the edge that accepted the enabling write.
- R6: rst_req_o is high for exactly one cycle, (P+Q)*D edges after that same edge, where Q is the stage-two preload (0 counts as 1). It is never high in the same cycle as irq_o. Counting then continues from stage one.
- R7: After a reset request, bit 9 of the reload register reads as 1.
- R8: The timeout flag stays set until power-on reset or an unlocked write to the reload register with bit 9 set. A locked write with bit 9 set does not clear it.
- R9: When configuration bits [3:2] equal 2'b10, irq_o stays low. The timing of the reset request does not change.
- R10: An unlocked write to the reload register with bit 8 set restarts the countdown from the stage-one preload. The next irq_o then comes P*D edges after that write.
- R11: While the block is disabled, neither irq_o nor rst_req_o is asserted.
- R12: After power-on reset, the registers read as follows: configuration 0, enable 0, stage-one preload PRE1_INIT, stage-two preload PRE2_INIT, timeout flag 0. Both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for both writes and reads |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for the register at addr |
| irq_o | output | 1 | One-cycle first-stage expiry interrupt |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The countdown is exercised with three kinds of stimulus:
- Directed preload pairs in both tick modes. These separate the fast divisor from the slow one and show whether the second stage is counted from the first-stage expiry or from the enabling write.
- A random mix of preload values, including zero, together with random mode and interrupt-mask settings. Exact edge counts expose off-by-one errors in the counters and in the prescaler.
- Broken key sequences, a protected write repeated after one unlock, and locked clears of the flag. These separate honoured writes from ignored ones.

A mid-count reload and a disable during counting show whether the restart and the hold actually take effect.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CFG    = 3'd0;
  localparam logic [ADDR_W-1:0] A_EN     = 3'd1;
  localparam logic [ADDR_W-1:0] A_PRE1   = 3'd2;
  localparam logic [ADDR_W-1:0] A_PRE2   = 3'd3;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd4;

  localparam logic [7:0] KEY_FIRST  = 8'h80;
  localparam logic [7:0] KEY_SECOND = 8'h86;

  localparam int RLD_BIT      = 8;
  localparam int TOUT_BIT     = 9;
  localparam int CFG_FAST_BIT = 0;
  localparam int CFG_W        = 4;

  localparam logic [1:0] IRQ_MASKED = 2'b10;

  typedef enum logic [1:0] {UL_IDLE, UL_KEY1, UL_ARMED} unlock_e;
  typedef enum logic {ST_ONE, ST_TWO} stage_e;
endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock import wdog_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              grant
);
  unlock_e st_q, st_d;
  logic    prot;

  always_comb begin
    prot  = (addr == A_PRE1) || (addr == A_PRE2) || (addr == A_RELOAD);
    grant = wr_en && prot && (st_q == UL_ARMED);
    st_d  = st_q;
    if (wr_en && prot) begin
      unique case (st_q)
        UL_IDLE:
          st_d = (addr == A_RELOAD && wdata == DATA_W'(KEY_FIRST)) ? UL_KEY1 : UL_IDLE;
        UL_KEY1:
          st_d = (addr == A_RELOAD && wdata == DATA_W'(KEY_SECOND)) ? UL_ARMED : UL_IDLE;
        default:
          st_d = UL_IDLE;  // armed write consumed
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) st_q <= UL_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/wdog_presc.sv
module wdog_presc #(
  parameter int DIV_FAST = 32,
  parameter int DIV_SLOW = 32768
) (
  input  logic clk,
  input  logic por_n,
  input  logic clr,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int PW      = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;
  localparam logic [PW-1:0] LIM_F = PW'(DIV_FAST - 1);
  localparam logic [PW-1:0] LIM_S = PW'(DIV_SLOW - 1);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] lim;

  assign lim  = fast ? LIM_F : LIM_S;
  assign tick = run && (cnt_q >= lim);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (run) cnt_q <= tick ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdog_stages.sv
module wdog_stages import wdog_pkg::*; #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             load,
  input  logic             tick,
  input  logic             irq_en,
  input  logic [CNT_W-1:0] pre1,
  input  logic [CNT_W-1:0] pre2,
  output logic             irq_o,
  output logic             rst_req_o
);
  stage_e           st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             expire;

  // A stage ends on the tick that finds one (or zero) count left.
  assign expire = tick && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st_q      <= ST_ONE;
      cnt_q     <= '0;
      irq_o     <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      irq_o     <= 1'b0;
      rst_req_o <= 1'b0;
      if (load) begin
        st_q  <= ST_ONE;
        cnt_q <= pre1;
      end else if (expire) begin
        if (st_q == ST_ONE) begin
          irq_o <= irq_en;
          st_q  <= ST_TWO;
          cnt_q <= pre2;
        end else begin
          rst_req_o <= 1'b1;
          st_q      <= ST_ONE;
          cnt_q     <= pre1;
        end
      end else if (tick) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdog_top.sv
module wdog_top import wdog_pkg::*; #(
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 24,
  parameter int DIV_FAST  = 32,
  parameter int DIV_SLOW  = 32768,
  parameter int PRE1_INIT = 1000,
  parameter int PRE2_INIT = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic [CFG_W-1:0] cfg_q;
  logic             en_q;
  logic [CNT_W-1:0] pre1_q, pre2_q;
  logic             flag_q;
  logic             grant;
  logic             start, reload, tick, irq_en;

  wdog_unlock #(.DATA_W(DATA_W)) u_unlock (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .grant(grant)
  );

  assign start  = wr_en && (addr == A_EN) && wdata[0] && !en_q;
  assign reload = grant && (addr == A_RELOAD) && wdata[RLD_BIT];
  assign irq_en = (cfg_q[3:2] != IRQ_MASKED);

  wdog_presc #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_presc (
    .clk(clk), .por_n(por_n), .clr(start || reload), .run(en_q),
    .fast(cfg_q[CFG_FAST_BIT]), .tick(tick)
  );

  wdog_stages #(.CNT_W(CNT_W)) u_stages (
    .clk(clk), .por_n(por_n), .load(start || reload), .tick(tick), .irq_en(irq_en),
    .pre1(pre1_q), .pre2(pre2_q), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cfg_q  <= '0;
      en_q   <= 1'b0;
      pre1_q <= CNT_W'(PRE1_INIT);
      pre2_q <= CNT_W'(PRE2_INIT);
      flag_q <= 1'b0;
    end else begin
      if (wr_en && addr == A_CFG) cfg_q <= wdata[CFG_W-1:0];
      if (wr_en && addr == A_EN)  en_q  <= wdata[0];
      if (grant && addr == A_PRE1) pre1_q <= wdata[CNT_W-1:0];
      if (grant && addr == A_PRE2) pre2_q <= wdata[CNT_W-1:0];
      // Setting outranks clearing; the flag ignores the request it records.
      if (rst_req_o) flag_q <= 1'b1;
      else if (grant && addr == A_RELOAD && wdata[TOUT_BIT]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CFG:    rdata = DATA_W'(cfg_q);
      A_EN:     rdata = DATA_W'(en_q);
      A_PRE1:   rdata = DATA_W'(pre1_q);
      A_PRE2:   rdata = DATA_W'(pre2_q);
      A_RELOAD: rdata[TOUT_BIT] = flag_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk import wdog_pkg::*; #(
  parameter int CNT_W = 24
) (
  input logic              clk,
  input logic              por_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              irq_o,
  input logic              rst_req_o,
  input logic              en_q,
  input logic [CFG_W-1:0]  cfg_q,
  input logic [CNT_W-1:0]  pre1_q,
  input logic              flag_q,
  input logic              grant
);
  assert_rst_single_R6: assert property (@(posedge clk) disable iff (!por_n)
    rst_req_o |=> !rst_req_o);
  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!por_n)
    irq_o |-> !rst_req_o);
  assert_locked_ignored_R2: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && addr == A_PRE1 && !grant) |=> $stable(pre1_q));
  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!por_n)
    rst_req_o |=> flag_q);
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!por_n)
    $fell(flag_q) |-> $past(wr_en && addr == A_RELOAD && grant));
  assert_quiet_off_R11: assert property (@(posedge clk) disable iff (!por_n)
    !en_q |=> (!irq_o && !rst_req_o));
  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_q[3:2] == IRQ_MASKED) |=> !irq_o);
endmodule

bind wdog_top wdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .por_n(por_n), .wr_en(wr_en), .addr(addr), .irq_o(irq_o),
  .rst_req_o(rst_req_o), .en_q(en_q), .cfg_q(cfg_q), .pre1_q(pre1_q),
  .flag_q(flag_q), .grant(grant)
);

// File: tb/sim_wdog_top.sv
`timescale 1ns/100ps
module sim_wdog_top;
  localparam int DW = 32;
  localparam int CW = 16;
  localparam int DF = 4;
  localparam int DS = 16;
  localparam int P1I = 1000;
  localparam int P2I = 2;

  logic          clk = 1'b0;
  logic          por_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq_o, rst_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_top #(.DATA_W(DW), .CNT_W(CW), .DIV_FAST(DF), .DIV_SLOW(DS),
             .PRE1_INIT(P1I), .PRE2_INIT(P2I)) u0 (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  function automatic int exp_span(int pre, int div);
    return ((pre < 1) ? 1 : pre) * div;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic uwr(input logic [2:0] a, input int d);
    wr(3'd4, 'h80);
    wr(3'd4, 'h86);
    wr(a, d);
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    @(negedge clk);
    addr = a;
    #1 d = int'(rdata);
  endtask

  task automatic measure(input int limit, output int t_irq, output int t_rst, output int n_irq);
    t_irq = -1; t_rst = -1; n_irq = 0;
    for (int n = 1; n <= limit; n++) begin
      @(posedge clk); #1;
      if (irq_o) begin n_irq++; if (t_irq < 0) t_irq = n; end
      if (rst_req_o) begin t_rst = n; break; end
    end
  endtask

  // One full countdown; expectations come from exp_span.
  task automatic run_case(string tag, int p, int q, bit fast, bit mask);
    int ti, tr, ni, d;
    d = fast ? DF : DS;
    uwr(3'd2, p);
    uwr(3'd3, q);
    wr(3'd0, (mask ? 32'hC >> 1 << 1 & 32'h8 : 0) | int'(fast));
    wr(3'd1, 1);
    measure(exp_span(p, d) + exp_span(q, d) + 10, ti, tr, ni);
    wr(3'd1, 0);
    chk({tag, " R6 reset time"}, tr, exp_span(p, d) + exp_span(q, d));
    if (mask) begin
      chk({tag, " R9 masked irq count"}, ni, 0);
    end else begin
      chk({tag, " R5 irq time"}, ti, exp_span(p, d));
      chk({tag, " R5 irq count"}, ni, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, ti, tr, ni;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 por_n = 1'b1;

    // R12 reset state
    chk("R12 irq low", int'(irq_o), 0);
    chk("R12 rst low", int'(rst_req_o), 0);
    rd(3'd0, v); chk("R12 cfg", v, 0);
    rd(3'd1, v); chk("R12 enable", v, 0);
    rd(3'd2, v); chk("R12 pre1", v, P1I);
    rd(3'd3, v); chk("R12 pre2", v, P2I);
    rd(3'd4, v); chk("R12 flag", v, 0);

    // R2 locked and broken sequences
    wr(3'd2, 5);
    rd(3'd2, v); chk("R2 plain write ignored", v, P1I);
    wr(3'd4, 'h80); wr(3'd4, 'h85); wr(3'd2, 11);
    rd(3'd2, v); chk("R2 wrong second key", v, P1I);
    wr(3'd4, 'h80); wr(3'd3, 9); wr(3'd4, 'h86); wr(3'd2, 12);
    rd(3'd2, v); chk("R2 interrupted sequence", v, P1I);
    wr(3'd4, 'h80); wr(3'd0, 0); wr(3'd4, 'h86); wr(3'd2, 13);
    rd(3'd2, v); chk("R2 config write keeps sequence", v, 13);

    // R1 one unlock arms exactly one write
    uwr(3'd2, 7);
    rd(3'd2, v); chk("R1 unlocked write", v, 7);
    wr(3'd2, 9);
    rd(3'd2, v); chk("R1 second write ignored", v, 7);

    // R3/R5/R6 fast and slow directed
    run_case("fast 3/2", 3, 2, 1'b1, 1'b0);
    rd(3'd4, v); chk("R7 flag set", (v >> 9) & 1, 1);
    run_case("slow 2/1", 2, 1, 1'b0, 1'b0);
    chk("R3 slow divisor used", exp_span(2, DS), 32);

    // R8 flag persistence and clearing
    repeat (20) @(posedge clk);
    rd(3'd4, v); chk("R8 flag persists", (v >> 9) & 1, 1);
    wr(3'd4, 1 << 9);
    rd(3'd4, v); chk("R8 locked clear ignored", (v >> 9) & 1, 1);
    uwr(3'd4, 1 << 9);
    rd(3'd4, v); chk("R8 unlocked clear", (v >> 9) & 1, 0);

    // R9 masked interrupt
    run_case("masked", 2, 2, 1'b1, 1'b1);

    // R10 reload mid-count
    uwr(3'd2, 5); uwr(3'd3, 2);
    wr(3'd0, 1);
    wr(3'd1, 1);
    measure(10, ti, tr, ni);
    chk("R10 no irq before reload", ni, 0);
    uwr(3'd4, 1 << 8);
    measure(exp_span(5, DF) + exp_span(2, DF) + 10, ti, tr, ni);
    wr(3'd1, 0);
    chk("R10 irq after reload", ti, exp_span(5, DF));
    chk("R10 reset after reload", tr, exp_span(5, DF) + exp_span(2, DF));

    // R4/R11 disable during counting
    uwr(3'd2, 2); uwr(3'd3, 1);
    wr(3'd1, 1);
    measure(3, ti, tr, ni);
    wr(3'd1, 0);
    measure(300, ti, tr, ni);
    chk("R11 no irq while off", ni, 0);
    chk("R11 no reset while off", tr, -1);
    rd(3'd1, v); chk("R4 enable reads 0", v, 0);

    // Random mix
    for (int i = 0; i < 20; i++) begin
      int p, q;
      bit f, m;
      p = int'($urandom % 7);
      q = int'($urandom % 5);
      f = 1'($urandom % 2);
      m = 1'($urandom % 2);
      run_case($sformatf("rand%0d", i), p, q, f, m);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule